// File: doc/BRIEF.md
# Mode-Switched Parallel I/O Port

This block is one 8-bit parallel port of a microcontroller-style chip. In the general-purpose modes, software owns every pin through three registers. A data latch holds the output values. A direction register chooses, per pin, whether the pin drives or listens. A pull-up register enables the weak pull-up on pins that are listening. Reads of the data address can happen at any time. Each bit returns the latched driver value when its pin is an output, and the synchronized pin level when it is an input.

In the external-bus modes the chip lends the pins to its memory bus. A parameter picks the flavour of the instance. The address-style instance drives the high byte of the bus address on all pins. The data-style instance becomes a bidirectional data bus: it drives on a bus-write strobe and forwards pin levels to a bus read-data output. Register writes still land in the latches while the bus owns the pins, and they take effect once a general-purpose mode returns.

Top module: `muxport`

## Requirements
- R1: After reset the data, direction and pull-up registers hold 0. In modes 00 and 10 every pin is therefore an input (pinOe = 0).
- R2: A write with regAddr = 0 stores regWrData in the data latch in the same clock edge. With every direction bit at 1, a read at address 0 then returns the written value.
- R3: A write with regAddr = 1 stores the direction register, where bit value 1 makes that pin an output. Reads at address 1 return it combinationally.
- R4: A read at address 0 returns, for each output pin, the data-latch bit, and for each input pin, pinIn delayed through a two-flop synchronizer. A pinIn change before edge k is visible after edge k+1. Address 3 reads 0.
- R5: In mode 00 (single-chip) and mode 10 (bootstrap), pinOe equals the direction register and pinOut equals the data latch.
- R6: In the address-style instance (IS_DATA = 0), in mode 01 (expanded) and mode 11 (test), pinOe is all ones and pinOut equals busAddrHi, whatever the registers hold.
- R7: In the data-style instance (IS_DATA = 1), in modes 01 and 11, pinOe is all ones while busWrStrobe is 1 and all zeros otherwise, and pinOut equals busWrData.
- R8: busRdData equals pinIn for the data-style instance in modes 01 and 11. It is 0 in every other case.
- R9: A write with regAddr = 2 stores the pull-up register. pullEn is that register with every bit cleared whose pin has pinOe = 1.
- R10: Register writes made in modes 01 or 11 update the latches without changing the pins. The written values drive the pins after a return to mode 00 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| regAddr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | W | Register write data |
| regRdData | output | W | Register read data, same cycle |
| busAddrHi | input | W | High address byte driven by the address-style instance in bus modes |
| busWrStrobe | input | 1 | Bus write strobe; enables the data-style drivers in bus modes |
| busWrData | input | W | Data driven on the pins by the data-style instance during bus writes |
| busRdData | output | W | Pin levels forwarded to the bus |
| pinIn | input | W | Pad input levels |
| pinOut | output | W | Pad output values |
| pinOe | output | W | Pad output enables |
| pullEn | output | W | Pad pull-up enables |

## Verification
Bound properties check the following on every clock:
- the pin ownership rules of each mode, for both the address-style and data-style variants;
- the forwarding of pin levels to the bus;
- the exclusion of pull-ups on driven pins;
- the effect of a data or direction write on the pins in the next cycle;
- the pin state just after reset.

The readback mix of latch and synchronized pin values, with its two-cycle delay, is shown only by the bench scenarios, which compare both variants against a behavioural model on every cycle. So is the carry-over of latch writes made while the bus owned the pins.

// File: rtl/muxport_pkg.sv
package muxport_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } portMode_t;

  typedef enum logic [1:0] {
    SEL_PORT = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } readSel_t;

  typedef struct packed {
    logic     wrData;
    logic     wrDir;
    logic     wrPull;
    logic     busOwn;
    logic     busDrive;
    readSel_t rdSel;
  } portCtrl_t;

endpackage

// File: rtl/muxport_ctrl.sv
module muxport_ctrl
  import muxport_pkg::*;
#(
  parameter bit IS_DATA = 1'b1
) (
  input  logic [1:0]            mode,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  busWrStrobe,
  output portCtrl_t             ctrl
);

  portMode_t modeSel;
  readSel_t  addrSel;
  logic      busOwn;

  assign modeSel = portMode_t'(mode);
  assign addrSel = readSel_t'(regAddr);

  always_comb begin
    unique case (modeSel)
      MODE_EXPAND, MODE_TEST: busOwn = 1'b1;
      default:                busOwn = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.wrData   = regWrEn && (addrSel == SEL_PORT);
    ctrl.wrDir    = regWrEn && (addrSel == SEL_DIR);
    ctrl.wrPull   = regWrEn && (addrSel == SEL_PULL);
    ctrl.busOwn   = busOwn;
    ctrl.busDrive = busOwn && (IS_DATA ? busWrStrobe : 1'b1);
    ctrl.rdSel    = addrSel;
  end

endmodule

// File: rtl/muxport_dp.sv
module muxport_dp
  import muxport_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit IS_DATA     = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  portCtrl_t    ctrl,
  input  logic [W-1:0] regWrData,
  input  logic [W-1:0] busAddrHi,
  input  logic [W-1:0] busWrData,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] regRdData,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] pinOe,
  output logic [W-1:0] pullEn,
  output logic [W-1:0] busRdData
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [W-1:0] dataQ, dirQ, pullQ;
  logic [W-1:0] syncQ [SYNC_STAGES];
  logic [W-1:0] pinSync, portView, busSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      pullQ <= '0;
    end else begin
      if (ctrl.wrData) dataQ <= regWrData;
      if (ctrl.wrDir)  dirQ  <= regWrData;
      if (ctrl.wrPull) pullQ <= regWrData;
    end
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= '0;
      else if (g == 0) syncQ[g] <= pinIn;
      else syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
    end
  end

  assign pinSync  = syncQ[LAST];
  assign portView = (dirQ & dataQ) | (~dirQ & pinSync);

  always_comb begin
    unique case (ctrl.rdSel)
      SEL_PORT: regRdData = portView;
      SEL_DIR:  regRdData = dirQ;
      SEL_PULL: regRdData = pullQ;
      default:  regRdData = '0;
    endcase
  end

  assign busSrc    = IS_DATA ? busWrData : busAddrHi;
  assign pinOut    = ctrl.busOwn ? busSrc : dataQ;
  assign pinOe     = ctrl.busOwn ? {W{ctrl.busDrive}} : dirQ;
  assign pullEn    = pullQ & ~pinOe;
  assign busRdData = (IS_DATA && ctrl.busOwn) ? pinIn : '0;

endmodule

// File: rtl/muxport.sv
module muxport
  import muxport_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit IS_DATA     = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            mode,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [W-1:0]          regWrData,
  output logic [W-1:0]          regRdData,
  input  logic [W-1:0]          busAddrHi,
  input  logic                  busWrStrobe,
  input  logic [W-1:0]          busWrData,
  output logic [W-1:0]          busRdData,
  input  logic [W-1:0]          pinIn,
  output logic [W-1:0]          pinOut,
  output logic [W-1:0]          pinOe,
  output logic [W-1:0]          pullEn
);

  portCtrl_t ctrl;

  muxport_ctrl #(.IS_DATA(IS_DATA)) u_ctrl (
    .mode        (mode),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .busWrStrobe (busWrStrobe),
    .ctrl        (ctrl)
  );

  muxport_dp #(.W(W), .SYNC_STAGES(SYNC_STAGES), .IS_DATA(IS_DATA)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .regWrData (regWrData),
    .busAddrHi (busAddrHi),
    .busWrData (busWrData),
    .pinIn     (pinIn),
    .regRdData (regRdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pullEn    (pullEn),
    .busRdData (busRdData)
  );

endmodule

// File: rtl/muxport_chk.sv
module muxport_chk #(
  parameter int W       = 8,
  parameter bit IS_DATA = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   mode,
  input logic [1:0]   regAddr,
  input logic         regWrEn,
  input logic [W-1:0] regWrData,
  input logic [W-1:0] busAddrHi,
  input logic         busWrStrobe,
  input logic [W-1:0] busWrData,
  input logic [W-1:0] busRdData,
  input logic [W-1:0] pinIn,
  input logic [W-1:0] pinOut,
  input logic [W-1:0] pinOe,
  input logic [W-1:0] pullEn
);

  logic gpio;
  assign gpio = (mode == 2'b00) || (mode == 2'b10);

  p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstN) && gpio) |-> (pinOe == '0));

  p_data_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && gpio) |=> (!gpio || pinOut == $past(regWrData)));

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && gpio) |=> (!gpio || pinOe == $past(regWrData)));

  p_addr_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!IS_DATA && !gpio) |-> (pinOe == '1 && pinOut == busAddrHi));

  p_data_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (IS_DATA && !gpio) |-> (pinOe == {W{busWrStrobe}} && pinOut == busWrData));

  p_bus_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    busRdData == ((IS_DATA && !gpio) ? pinIn : '0));

  p_pull_off_driven_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & pinOe) == '0);

endmodule

bind muxport muxport_chk #(.W(W), .IS_DATA(IS_DATA)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .mode        (mode),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .busAddrHi   (busAddrHi),
  .busWrStrobe (busWrStrobe),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .pinIn       (pinIn),
  .pinOut      (pinOut),
  .pinOe       (pinOe),
  .pullEn      (pullEn)
);

// File: tb/muxport_tb.sv
`timescale 1ns/1ps
module muxport_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [1:0]   regAddr = 2'd0;
  logic         regWrEn = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] busAddrHi = '0;
  logic         busWrStrobe = 1'b0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] pinIn = '0;

  logic [W-1:0] dRd, dBus, dOut, dOe, dPull;
  logic [W-1:0] aRd, aBus, aOut, aOe, aPull;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  logic [W-1:0] mData, mDir, mPull, s1, s2;

  always #2.5 clk = ~clk;

  muxport #(.W(W), .IS_DATA(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(dRd), .busAddrHi(busAddrHi),
    .busWrStrobe(busWrStrobe), .busWrData(busWrData), .busRdData(dBus),
    .pinIn(pinIn), .pinOut(dOut), .pinOe(dOe), .pullEn(dPull));

  muxport #(.W(W), .IS_DATA(1'b0)) u_addr (
    .clk(clk), .rstN(rstN), .mode(mode), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(aRd), .busAddrHi(busAddrHi),
    .busWrStrobe(busWrStrobe), .busWrData(busWrData), .busRdData(aBus),
    .pinIn(pinIn), .pinOut(aOut), .pinOe(aOe), .pullEn(aPull));

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit isGpio();
    return (mode == 2'b00) || (mode == 2'b10);
  endfunction

  task automatic compareAll();
    logic [W-1:0] eRd, eOe, eOut, eBus;
    string oTag;
    bit g;
    g = isGpio();
    case (regAddr)
      2'd0: eRd = (mDir & mData) | (~mDir & s2);
      2'd1: eRd = mDir;
      2'd2: eRd = mPull;
      default: eRd = '0;
    endcase
    // data-style instance
    eOe  = g ? mDir : {W{busWrStrobe}};
    eOut = g ? mData : busWrData;
    eBus = g ? '0 : pinIn;
    oTag = !rstN ? "R1" : (g ? "R5" : "R7");
    check(dRd === eRd, "R4 data-port read", dRd, eRd);
    check(dOe === eOe, {oTag, " data-port oe"}, dOe, eOe);
    check(dOut === eOut, {oTag, " data-port out"}, dOut, eOut);
    check(dBus === eBus, "R8 data-port bus read", dBus, eBus);
    check(dPull === (mPull & ~eOe), "R9 data-port pull", dPull, mPull & ~eOe);
    // address-style instance
    eOe  = g ? mDir : '1;
    eOut = g ? mData : busAddrHi;
    oTag = !rstN ? "R1" : (g ? "R5" : "R6");
    check(aRd === eRd, "R4 addr-port read", aRd, eRd);
    check(aOe === eOe, {oTag, " addr-port oe"}, aOe, eOe);
    check(aOut === eOut, {oTag, " addr-port out"}, aOut, eOut);
    check(aBus === '0, "R8 addr-port bus read", aBus, '0);
    check(aPull === (mPull & ~eOe), "R9 addr-port pull", aPull, mPull & ~eOe);
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      mData = '0; mDir = '0; mPull = '0; s1 = '0; s2 = '0;
    end else begin
      if (regWrEn && regAddr == 2'd0) mData = regWrData;
      if (regWrEn && regAddr == 2'd1) mDir  = regWrData;
      if (regWrEn && regAddr == 2'd2) mPull = regWrData;
      s2 = s1;
      s1 = pinIn;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [W-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mData = '0; mDir = '0; mPull = '0; s1 = '0; s2 = '0;
    // R1: reset in single-chip mode
    idle(3);
    check(dOe === '0, "R1 inputs after reset", dOe, '0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R2/R3: set all outputs, write latch
    writeReg(2'd1, 8'hFF);
    writeReg(2'd0, 8'h96);
    regAddr = 2'd0;
    idle(1);
    check(dRd === 8'h96, "R2 data readback", dRd, 8'h96);
    regAddr = 2'd1;
    idle(1);
    check(aRd === 8'hFF, "R3 direction readback", aRd, 8'hFF);

    // R4: mixed directions with changing pins, synchronizer latency
    writeReg(2'd1, 8'hF0);
    writeReg(2'd0, 8'hA5);
    regAddr = 2'd0;
    pinIn = 8'h3C;
    idle(1);
    check(dRd[3:0] === 4'h0, "R4 pin not yet visible", {4'h0, dRd[3:0]}, 8'h00);
    idle(1);
    check(dRd === 8'hAC, "R4 mixed readback", dRd, 8'hAC);
    for (int i = 0; i < 8; i++) begin
      pinIn = 8'(i * 37 + 5);
      idle(1);
    end
    regAddr = 2'd3;
    idle(1);
    check(dRd === '0, "R4 unused address", dRd, '0);

    // R9: pull-ups only on input pins
    writeReg(2'd2, 8'hFF);
    check(dPull === 8'h0F, "R9 pull masked by oe", dPull, 8'h0F);

    // R5: bootstrap mode behaves as general-purpose
    mode = 2'b10;
    writeReg(2'd1, 8'h3C);
    idle(2);
    check(dOe === 8'h3C, "R5 bootstrap oe", dOe, 8'h3C);

    // R6/R7/R8/R10: expanded mode
    mode = 2'b01;
    busAddrHi = 8'hC3;
    busWrData = 8'h5E;
    pinIn = 8'h71;
    idle(1);
    check(aOut === 8'hC3, "R6 address on pins", aOut, 8'hC3);
    writeReg(2'd0, 8'h5A);
    busWrStrobe = 1'b1;
    idle(1);
    check(dOe === 8'hFF, "R7 strobe drives", dOe, 8'hFF);
    busWrStrobe = 1'b0;
    idle(1);
    check(dBus === 8'h71, "R8 bus read forward", dBus, 8'h71);
    for (int i = 0; i < 6; i++) begin
      busWrStrobe = i[0];
      busAddrHi = 8'(i * 29);
      busWrData = 8'(i * 53 + 1);
      pinIn = 8'(i * 11);
      idle(1);
    end
    busWrStrobe = 1'b0;

    // R6/R7 in test mode
    mode = 2'b11;
    writeReg(2'd1, 8'h00);
    idle(3);

    // R10: latch written in bus mode drives after returning
    mode = 2'b00;
    writeReg(2'd1, 8'hFF);
    check(dOut === 8'h5A, "R10 latched bus-mode write", dOut, 8'h5A);

    // R1: reset while in expanded mode
    mode = 2'b01;
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    @(negedge clk);
    rstN = 1'b1;
    mode = 2'b00;
    idle(2);
    check(aOe === '0, "R1 reset clears direction", aOe, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule